// File: doc/BRIEF.md
# SPI FIFO Level Interrupt Unit

This block holds the transmit and receive byte queues of an SPI controller. It keeps a count of the bytes held in each, packs both counts into one status word, and turns the fill levels and the end of a transfer into maskable interrupt requests. The shift engine sits outside the block. It appears only as push and pop strobes on the two queues and as a one-cycle transfer-done pulse. Software sees the block through a small word-wide register port with four addresses: an interrupt enable mask, a sticky interrupt status register that is cleared by writing ones, a write-only queue control word, and the packed level word.

There are three interrupt sources. The receive source fires when the receive queue reaches three quarters of its depth. The transmit source fires when the transmit queue has drained to one quarter or less. The done source fires on the transfer-done pulse. A level source is sticky, but it sets again on the cycle after a clear if its condition still holds. The interrupt line is the OR of every status flag gated by its enable bit.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: A read at address 3 returns the receive queue count in bits 7:0 and the transmit queue count in bits 23:16. Every other bit reads zero.
- R2: A push to a full queue (64 bytes by default) and a pop from an empty queue are ignored and leave the count unchanged. A push and a pop on a full queue in the same cycle drop the count by one.
- R3: Each queue returns bytes in the order they were pushed. The oldest byte is presented on its read-data port while the queue is not empty.
- R4: Status bit 1 (receive high) sets on the clock after the receive count is at least three quarters of the depth (48 by default).
- R5: Status bit 2 (transmit low) sets on the clock after the transmit count is at most one quarter of the depth (16 by default). It is therefore set one cycle after reset releases.
- R6: Status bit 0 (done) sets on the clock after a transfer-done pulse. It holds until software clears it.
- R7: Writing to address 1 clears each status bit written as one and leaves bits written as zero unchanged. A cleared level bit whose condition still holds sets again on the following clock. A done pulse in the same cycle as a clear of bit 0 keeps bit 0 set.
- R8: Address 0 bits 2:0 hold the enable mask, which reads back. The irq output is high exactly when some status bit and its enable bit are both one.
- R9: A write to address 2 with bit 31 set empties the transmit queue, and one with bit 15 set empties the receive queue. The empty takes priority over a push in the same cycle.
- R10: During reset and right after it, both counts, the enable mask and status bits 0 and 1 are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 status, 2 queue control, 3 levels) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Shift engine takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shift engine pushes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Software takes the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a receive queue held at or above three quarters, or completely full, while software clears the receive flag. The flag must drop for exactly one cycle and then return. Random push and pop traffic alone rarely stays up there, so the stimulus combines two things. Directed sequences fill the queue past the threshold and to the limit, then issue clears and overflow pushes. Random phases with a strong push bias then drift the counts back up to the threshold while clears, enable writes and queue empties arrive at random moments.

// File: rtl/spi_fiq_pkg.sv
package spi_fiq_pkg;
    localparam int IRQ_N  = 3;
    localparam int B_DONE = 0;
    localparam int B_RXHI = 1;
    localparam int B_TXLO = 2;

    localparam logic [1:0] A_EN   = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_FCTL = 2'd2;
    localparam logic [1:0] A_LVL  = 2'd3;

    localparam int TX_CLR_BIT = 31;
    localparam int RX_CLR_BIT = 15;
    localparam int FIELD_W    = 8;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_C = PTR_W'(DEPTH - 1);

    fifo_st_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok_d, pop_ok_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_C) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        push_ok_d = push && (s_q.cnt != FULL_C);
        pop_ok_d  = pop && (s_q.cnt != '0);
        if (push_ok_d) s_d.wptr = ptr_inc(s_q.wptr);
        if (pop_ok_d)  s_d.rptr = ptr_inc(s_q.rptr);
        case ({push_ok_d, pop_ok_d})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok_d && !clr) mem_q[s_q.wptr] <= wdata;
    end

    assign rdata = mem_q[s_q.rptr];
    assign count = s_q.cnt;

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_C);
    p_full_push_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && s_q.cnt == FULL_C) |=> (s_q.cnt == FULL_C));
    p_empty_pop_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && s_q.cnt == '0) |=> (s_q.cnt == '0));
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0));
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import spi_fiq_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic             xfer_done,
    input  logic [IRQ_N-1:0] w1c,
    output logic [IRQ_N-1:0] flags
);
    localparam logic [CNT_W-1:0] RX_HI_C = CNT_W'((3 * DEPTH) / 4);
    localparam logic [CNT_W-1:0] TX_LO_C = CNT_W'(DEPTH / 4);

    typedef struct packed {
        logic [IRQ_N-1:0] flg;
    } flag_st_t;

    flag_st_t s_d, s_q;
    logic [IRQ_N-1:0] cond_d;

    always_comb begin
        cond_d         = '0;
        cond_d[B_DONE] = xfer_done;
        cond_d[B_RXHI] = (rx_cnt >= RX_HI_C);
        cond_d[B_TXLO] = (tx_cnt <= TX_LO_C);
        s_d = s_q;
        for (int i = 0; i < IRQ_N; i++) begin
            if (i == B_DONE) begin
                s_d.flg[i] = cond_d[i] | (s_q.flg[i] & ~w1c[i]);
            end else begin
                s_d.flg[i] = w1c[i] ? 1'b0 : (s_q.flg[i] | cond_d[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.flg;

    p_rxhi_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= RX_HI_C && !w1c[B_RXHI]) |=> flags[B_RXHI]);
    p_txlo_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= TX_LO_C && !w1c[B_TXLO]) |=> flags[B_TXLO]);
    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> flags[B_DONE]);
    p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[B_DONE] && !w1c[B_DONE]) |=> flags[B_DONE]);
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        w1c[B_RXHI] |=> !flags[B_RXHI]);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fiq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              xfer_done,
    output logic              irq
);
    typedef struct packed {
        logic [IRQ_N-1:0] en;
    } ctl_st_t;

    ctl_st_t s_d, s_q;
    logic [IRQ_N-1:0] w1c_d;
    logic [IRQ_N-1:0] flags;
    logic             tx_clr_d, rx_clr_d;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata[30:16], reg_wdata[14:IRQ_N]};

    always_comb begin
        s_d      = s_q;
        w1c_d    = '0;
        tx_clr_d = 1'b0;
        rx_clr_d = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_EN:    s_d.en   = reg_wdata[IRQ_N-1:0];
                A_STAT:  w1c_d    = reg_wdata[IRQ_N-1:0];
                A_FCTL: begin
                    tx_clr_d = reg_wdata[TX_CLR_BIT];
                    rx_clr_d = reg_wdata[RX_CLR_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr_d),
        .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_rdata), .count(tx_cnt)
    );

    byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr_d),
        .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .count(rx_cnt)
    );

    irq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
        .xfer_done(xfer_done), .w1c(w1c_d),
        .flags(flags)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN:    reg_rdata[IRQ_N-1:0] = s_q.en;
            A_STAT:  reg_rdata[IRQ_N-1:0] = flags;
            A_LVL:   reg_rdata = {8'b0, FIELD_W'(tx_cnt), 8'b0, FIELD_W'(rx_cnt)};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |(flags & s_q.en);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en == '0) |-> !irq);
    p_enable_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EN) |=> (s_q.en == $past(reg_wdata[IRQ_N-1:0])));
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (s_q.en == '0));
endmodule

// File: tb/tb_spi_fifo_irq_unit.sv
module tb_spi_fifo_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]  tx_wdata = '0, rx_wdata = '0;
    logic [7:0]  tx_rdata, rx_rdata;
    logic        xfer_done = 1'b0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit run_over = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [2:0] m_flags = '0;
    logic [2:0] m_en = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_fifo_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .xfer_done(xfer_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_levels();
        return {8'b0, 8'(txq.size()), 8'b0, 8'(rxq.size())};
    endfunction

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Requirement-level reference: flag rules R4-style thresholds from old counts
    task automatic model_step();
        int old_tx, old_rx;
        logic [2:0] w1c;
        logic clr_tx, clr_rx;
        old_tx = txq.size();
        old_rx = rxq.size();
        w1c    = (reg_wr && reg_addr == 2'd1) ? reg_wdata[2:0] : 3'b000;
        clr_tx = reg_wr && reg_addr == 2'd2 && reg_wdata[31];
        clr_rx = reg_wr && reg_addr == 2'd2 && reg_wdata[15];
        m_flags[0] = xfer_done | (m_flags[0] & ~w1c[0]);
        m_flags[1] = w1c[1] ? 1'b0 : (m_flags[1] | (old_rx >= 48));
        m_flags[2] = w1c[2] ? 1'b0 : (m_flags[2] | (old_tx <= 16));
        if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[2:0];
        if (clr_tx) txq.delete();
        else begin
            if (tx_pop && old_tx > 0) void'(txq.pop_front());
            if (tx_push && old_tx < DEPTH) txq.push_back(tx_wdata);
        end
        if (clr_rx) rxq.delete();
        else begin
            if (rx_pop && old_rx > 0) void'(rxq.pop_front());
            if (rx_push && old_rx < DEPTH) rxq.push_back(rx_wdata);
        end
    endtask

    task automatic check_all();
        logic [31:0] v;
        rd(2'd3, v);
        chk("R1 level word", v, exp_levels());
        rd(2'd1, v);
        chk("R4 R5 R6 R7 status", v, {29'b0, m_flags});
        chk("R8 irq", {31'b0, irq}, {31'b0, |(m_flags & m_en)});
        if (txq.size() > 0) chk("R3 tx head", {24'b0, tx_rdata}, {24'b0, txq[0]});
        if (rxq.size() > 0) chk("R3 rx head", {24'b0, rx_rdata}, {24'b0, rxq[0]});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        reg_wr = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; xfer_done = 0;
        reg_wdata = '0;
        check_all();
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!run_over) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        // R10: values during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(2'd3, v); chk("R10 levels in reset", v, 32'h0);
        rd(2'd0, v); chk("R10 enable in reset", v, 32'h0);
        rd(2'd1, v); chk("R10 status in reset", v, 32'h0);
        chk("R10 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1;
        tick();
        rd(2'd1, v); chk("R10 R5 status after reset", v, 32'h4);
        chk("R10 irq after reset", {31'b0, irq}, 32'h0);

        // R3: order on transmit queue
        tx_push = 1; tx_wdata = 8'hA1; tick();
        tx_push = 1; tx_wdata = 8'hB2; tick();
        tx_push = 1; tx_wdata = 8'hC3; tick();
        chk("R3 first byte", {24'b0, tx_rdata}, 32'hA1);
        tx_pop = 1; tick();
        chk("R3 second byte", {24'b0, tx_rdata}, 32'hB2);
        tx_pop = 1; tick();
        chk("R3 third byte", {24'b0, tx_rdata}, 32'hC3);

        // R2: pop from empty receive queue
        rx_pop = 1; tick();
        rd(2'd3, v); chk("R2 pop empty", {24'b0, v[7:0]}, 32'd0);

        // R2 R4: fill receive queue to the limit and beyond
        for (int i = 0; i < DEPTH + 3; i++) begin
            rx_push = 1; rx_wdata = 8'(i * 7 + 1); tick();
        end
        rd(2'd3, v); chk("R2 full stays", {24'b0, v[7:0]}, 32'd64);
        rd(2'd1, v); chk("R4 rx high set", {31'b0, v[1]}, 32'd1);
        chk("R2 head kept", {24'b0, rx_rdata}, 32'd1);
        rx_push = 1; rx_pop = 1; rx_wdata = 8'hEE; tick();
        rd(2'd3, v); chk("R2 push+pop on full", {24'b0, v[7:0]}, 32'd63);

        // R7: clear with condition still true, then re-set
        wreg(2'd1, 32'h2);
        rd(2'd1, v); chk("R7 cleared", {31'b0, v[1]}, 32'd0);
        tick();
        rd(2'd1, v); chk("R7 set again", {31'b0, v[1]}, 32'd1);
        wreg(2'd1, 32'h0);
        rd(2'd1, v); chk("R7 zero write no effect", {31'b0, v[1]}, 32'd1);

        // R6 R8: done flag and masking
        wreg(2'd0, 32'h1);
        chk("R8 masked irq low", {31'b0, irq}, 32'd0);
        xfer_done = 1; tick();
        rd(2'd1, v); chk("R6 done set", {31'b0, v[0]}, 32'd1);
        chk("R8 irq on done", {31'b0, irq}, 32'd1);
        repeat (3) tick();
        rd(2'd1, v); chk("R6 done holds", {31'b0, v[0]}, 32'd1);
        reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h1; xfer_done = 1; tick();
        rd(2'd1, v); chk("R7 done pulse wins over clear", {31'b0, v[0]}, 32'd1);
        wreg(2'd1, 32'h1);
        rd(2'd1, v); chk("R6 done cleared", {31'b0, v[0]}, 32'd0);
        chk("R8 irq drops", {31'b0, irq}, 32'd0);
        rd(2'd0, v); chk("R8 enable readback", v, 32'h1);

        // R9: queue empties beat pushes
        reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h0000_8000; rx_push = 1; tick();
        rd(2'd3, v); chk("R9 rx emptied", {24'b0, v[7:0]}, 32'd0);
        tx_push = 1; tx_wdata = 8'h55; tick();
        reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h8000_0000; tx_push = 1; tick();
        rd(2'd3, v); chk("R9 tx emptied", {24'b0, v[23:16]}, 32'd0);

        // R5: transmit low threshold
        for (int i = 0; i < 17; i++) begin
            tx_push = 1; tx_wdata = 8'(i); tick();
        end
        wreg(2'd1, 32'h4);
        rd(2'd1, v); chk("R5 cleared at 17", {31'b0, v[2]}, 32'd0);
        tick();
        rd(2'd1, v); chk("R5 stays clear at 17", {31'b0, v[2]}, 32'd0);
        tx_pop = 1; tick();
        rd(2'd1, v); chk("R5 not yet at 16", {31'b0, v[2]}, 32'd0);
        tick();
        rd(2'd1, v); chk("R5 set at 16", {31'b0, v[2]}, 32'd1);

        // Random phases with changing push/pop bias
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 600; c++) begin
                int rp, rq, tp, tq, r;
                rp = (ph % 2 == 0) ? 85 : 30;
                rq = (ph % 2 == 0) ? 20 : 70;
                tp = (ph < 2) ? 75 : 25;
                tq = (ph < 2) ? 30 : 80;
                rx_push  = ($urandom_range(99) < rp);
                rx_pop   = ($urandom_range(99) < rq);
                tx_push  = ($urandom_range(99) < tp);
                tx_pop   = ($urandom_range(99) < tq);
                rx_wdata = 8'($urandom);
                tx_wdata = 8'($urandom);
                xfer_done = ($urandom_range(99) < 2);
                r = $urandom_range(199);
                if (r < 8) begin
                    reg_wr = 1; reg_addr = 2'd1; reg_wdata = {29'b0, 3'($urandom)};
                end else if (r < 12) begin
                    reg_wr = 1; reg_addr = 2'd0; reg_wdata = {29'b0, 3'($urandom)};
                end else if (r == 12) begin
                    reg_wr = 1; reg_addr = 2'd2;
                    reg_wdata = ($urandom_range(1) == 1) ? 32'h8000_0000 : 32'h0000_8000;
                end
                tick();
            end
        end

        run_over = 1;
        summary();
        $finish;
    end
endmodule